// File: doc/BRIEF.md
# Tap-Count Delay Controller

This block holds a small tap count and uses it to delay a single-cycle input pulse by that many fine ticks. In this synthesizable form, the control logic and the timing path share one clock, so one fine tick is one clock cycle. A real delay line would run its timing path on a faster clock. The block does not model calibration against process, voltage or temperature.

A parameter selects how the tap count is set, and it is fixed at elaboration:

- **Fixed mode** holds the count at a default value for the whole run.
- **Variable mode** steps the count up or down on an enable. A control reset returns it to the default.
- **Loadable mode** steps the same way, but its control reset copies the count from a load input.

In every mode the current count can be read on an output port.

A pulse takes the tap count that is current in the cycle it arrives, and keeps it for its whole flight. One countdown times the pulse. Any pulse that arrives while a delay is still pending is dropped.

Top module: `tap_delay_ctrl`

## Requirements
- R1: While `rst_n` is low, `tap_out` equals `DEFAULT_TAP` and `pulse_out` is 0.
- R2: With `MODE`=0 (fixed), `ce`, `inc`, `ctl_rst` and `load_val` have no effect, and `tap_out` stays at `DEFAULT_TAP`.
- R3: With `MODE`=1 or 2, if `ce` is high and `ctl_rst` is low at a clock edge, the count changes at that edge. It rises by one when `inc` is 1 and falls by one when `inc` is 0. It wraps modulo 32, so 31 goes to 0 and 0 goes to 31.
- R4: With `MODE`=1 (variable), `ctl_rst` high at an edge sets the count to `DEFAULT_TAP`. This takes priority over `ce`.
- R5: With `MODE`=2 (loadable), `ctl_rst` high at an edge sets the count to `load_val`. This takes priority over `ce`.
- R6: `tap_out` always shows the current count. A control action at an edge is visible in the cycle that follows.
- R7: Suppose `pulse_in` is high in cycle T, no delay is pending, and `tap_out` reads d in cycle T. Then `pulse_out` is high in cycle T+1+d only, for d from 0 to 31.
- R8: Changes to the count after cycle T do not alter the delay of the pulse launched in cycle T.
- R9: A `pulse_in` in any cycle from T+1 to T+d, while the delay is still pending, is dropped and produces no output pulse.
- R10: With `MODE`=1 or 2, if `ce` and `ctl_rst` are both low at an edge, the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for control and fine ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Step enable for the tap count |
| inc | input | 1 | Step direction: 1 up, 0 down |
| ctl_rst | input | 1 | Control reset: default value or load value, depending on mode |
| load_val | input | 5 | Value copied in by a control reset in loadable mode |
| tap_out | output | 5 | Current tap count |
| pulse_in | input | 1 | Pulse to be delayed |
| pulse_out | output | 1 | Delayed pulse |

## Verification
The assertions assume that `pulse_in` is a single-cycle strobe and that all control inputs are stable around the clock edge. They do not assume anything about pulse spacing, because the drop rule covers overlap.

The stimulus drives every input on the falling edge. It keeps `ce` low while a delay is being measured, and it changes the count during a flight only on purpose, in the in-flight check. Every measurement window is longer than the largest delay, so each test starts with no delay pending.

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl #(
  parameter int TAP_W       = 5,
  parameter int MODE        = 2,
  parameter int DEFAULT_TAP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             inc,
  input  logic             ctl_rst,
  input  logic [TAP_W-1:0] load_val,
  output logic [TAP_W-1:0] tap_out,
  input  logic             pulse_in,
  output logic             pulse_out
);
  localparam logic [TAP_W-1:0] DEF_T = TAP_W'(DEFAULT_TAP);
  localparam logic [TAP_W-1:0] ONE   = TAP_W'(1);
  localparam bit               ADJ   = (MODE != 0);

  logic [TAP_W-1:0] tap_q, tap_nxt, rst_val, cnt_q;
  logic             busy_q, fire_q;

  assign rst_val = (MODE == 2) ? load_val : DEF_T;

  always_comb begin
    tap_nxt = tap_q;
    if (ADJ) begin
      if (ctl_rst)  tap_nxt = rst_val;
      else if (ce)  tap_nxt = inc ? tap_q + ONE : tap_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tap_q <= DEF_T;
    else        tap_q <= tap_nxt;

  assign tap_out = tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          busy_q <= 1'b0;
          fire_q <= 1'b1;
        end
      end else if (pulse_in) begin
        if (tap_q == '0) fire_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          cnt_q  <= tap_q;
        end
      end
    end
  end

  assign pulse_out = fire_q;

  p_fixed_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0) |-> tap_out == DEF_T);
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ADJ && ce && inc && !ctl_rst) |=> tap_out == $past(tap_out) + ONE);
  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ADJ && ce && !inc && !ctl_rst) |=> tap_out == $past(tap_out) - ONE);
  p_rst_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 1 && ctl_rst) |=> tap_out == DEF_T);
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 2 && ctl_rst) |=> tap_out == $past(load_val));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !ctl_rst) |=> $stable(tap_out));
  p_zero_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_in && !busy_q && tap_out == '0) |=> pulse_out);
  p_no_early_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != ONE) |=> !pulse_out && busy_q);
endmodule

// File: tb/tap_delay_ctrl_tb.sv
module tap_delay_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, ce = 1'b0, inc = 1'b0, crst = 1'b0, pin = 1'b0;
  logic [4:0] lv = '0;
  logic [4:0] tf, tv, tl;
  logic po_f, po_v, po_l;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tap_delay_ctrl #(.TAP_W(5), .MODE(0), .DEFAULT_TAP(5)) u_fix (
    .clk(clk), .rst_n(rst_n), .ce(ce), .inc(inc), .ctl_rst(crst), .load_val(lv),
    .tap_out(tf), .pulse_in(pin), .pulse_out(po_f));
  tap_delay_ctrl #(.TAP_W(5), .MODE(1), .DEFAULT_TAP(5)) u_var (
    .clk(clk), .rst_n(rst_n), .ce(ce), .inc(inc), .ctl_rst(crst), .load_val(lv),
    .tap_out(tv), .pulse_in(pin), .pulse_out(po_v));
  tap_delay_ctrl #(.TAP_W(5), .MODE(2), .DEFAULT_TAP(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .inc(inc), .ctl_rst(crst), .load_val(lv),
    .tap_out(tl), .pulse_in(pin), .pulse_out(po_l));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int v);
    lv = 5'(v); crst = 1'b1; cyc(); crst = 1'b0;
  endtask

  task automatic measure(input int which, input int d, input string req,
                         input int extra_at, input int relo_at, input int relo_val);
    int first = -1;
    int cnt = 0;
    pin = 1'b1; cyc(); pin = 1'b0;
    for (int k = 1; k <= 45; k++) begin
      logic o;
      o = (which == 0) ? po_f : (which == 1) ? po_v : po_l;
      if (o) begin cnt++; if (first < 0) first = k; end
      pin  = (k == extra_at);
      crst = (k == relo_at);
      if (k == relo_at) lv = 5'(relo_val);
      cyc();
    end
    pin = 1'b0; crst = 1'b0;
    chk({req, " latency"}, first, 1 + d);
    chk({req, " pulse count"}, cnt, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    ce = 1'b1; inc = 1'b1; crst = 1'b1; lv = 5'd20;
    repeat (3) cyc();
    chk("R1 fixed tap", int'(tf), 5);
    chk("R1 variable tap", int'(tv), 5);
    chk("R1 loadable tap", int'(tl), 5);
    chk("R1 pulse_out", int'({po_f, po_v, po_l}), 0);
    ce = 1'b0; inc = 1'b0; crst = 1'b0;
    rst_n = 1'b1;
    cyc();

    measure(0, 5, "R7 fixed", 0, 0, 0);

    ce = 1'b1; inc = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      cyc();
      chk("R3 up/wrap", int'(tv), (5 + i) % 32);
      chk("R2 fixed ignores ce", int'(tf), 5);
    end
    inc = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      cyc();
      chk("R3 down/wrap", int'(tv), (3 - i + 32) % 32);
    end
    ce = 1'b0; inc = 1'b1;
    repeat (3) cyc();
    chk("R10 hold", int'(tv), 31);

    ce = 1'b1; crst = 1'b1; lv = 5'd17;
    cyc();
    chk("R4 default over ce", int'(tv), 5);
    chk("R5 load over ce", int'(tl), 17);
    chk("R2 fixed ignores ctl_rst", int'(tf), 5);
    crst = 1'b0; inc = 1'b0;
    cyc();
    chk("R6 readback after step", int'(tl), 16);
    chk("R3 loadable down", int'(tl), 16);
    ce = 1'b0;

    for (int d = 0; d < 32; d++) begin
      load(d);
      chk("R5 load", int'(tl), d);
      measure(2, d, "R7 sweep", 0, 0, 0);
    end

    load(10);
    measure(2, 10, "R8 in-flight", 0, 1, 2);
    chk("R8 new count visible", int'(tl), 2);

    load(8);
    measure(2, 8, "R9 drop while pending", 3, 0, 0);

    measure(1, 5, "R7 variable", 0, 0, 0);
    chk("R2 fixed final", int'(tf), 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule